// File: doc/BRIEF.md
# Keyed Flash Row Programming Controller

This block lets running software rewrite an on-chip program memory through a small register bus. Software first picks a target word address. For a row update it fills a holding buffer one instruction word at a time. Then it asks for one of three operations: erase a page, program a whole row from the buffer, or program one word. A request only takes effect when it comes straight after a two-value unlock handshake on a write-only key register. This keeps stray writes from changing the memory.

Once an operation starts, the block raises a busy output that stalls the requester for a fixed number of clock cycles, set by a parameter. During that window the block drives a simple write port toward a behavioural memory array: one address, one data word and one write strobe per word written. Erase works on 8-row pages aligned to the start of memory. Row programming works on 64-word rows aligned the same way.

Register map (3-bit bus address): 0 control, 1 key, 2 target address, 3 data low half, 4 data high half. Control bits: bit 15 is the start bit, bit 14 is the error flag, and bits 1:0 select the operation (1 = single word, 2 = row, 3 = page erase, 0 = none).

Top module: `flashprog_ctl`

## Requirements
- R1: After reset, busy and the memory write strobe are low, and a read of the control register returns 0.
- R2: A read of the key register (address 1) always returns 0.
- R3: A control write with bit 15 set starts an operation only when the write to key of 0x0055 is followed by a write to key of 0x00AA as the very next bus access, with the start write as the access right after that. Any other access in between, or a wrong value, cancels the unlock. A rejected start sets the error flag (control bit 14) and does not raise busy.
- R4: One unlock allows one start attempt only. A second start without a new unlock is rejected with the error flag.
- R5: Busy stays high for exactly OP_CYCLES cycles after an accepted start. Control bit 15 reads 1 during that time and 0 once it ends. The write strobe is only active while busy.
- R6: Page erase (operation 3) writes all-ones to the 512 words of the page that holds the target address (the low 9 address bits are forced to 0), in ascending order.
- R7: Row program (operation 2) writes the 64 buffered words to their 64-word-aligned row in ascending order. Afterwards the buffer is empty, so a new row start is rejected.
- R8: Single-word program (operation 1) writes the word made of {high half bits 7:0, low half bits 15:0} to the target address.
- R9: Loading the buffer takes two bus writes: data low half (address 3), then data high half (address 4). The second write stores the full word at buffer slot target address bits 5:0.
- R10: A high-half write whose target row (address bits 15:6) differs from the row of the words already in the buffer sets the error flag and is not stored.
- R11: A row start while any of the 64 buffer slots is empty is rejected with the error flag.
- R12: Bus writes made while busy is high are ignored.
- R13: Writing the control register with bit 14 set clears the error flag.
- R14: A start with operation code 0 is rejected with the error flag, even after a valid unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the selected register |
| busy | output | 1 | Operation in progress; requester stalls |
| mem_we | output | 1 | Memory array write strobe |
| mem_addr | output | ADDR_W | Memory array word address |
| mem_wdata | output | WORD_W | Memory array write data |

## Verification
The unlock gate is tried with the correct pair and with three faulty patterns: no key at all, a read placed between the two key writes, and the two values in reverse order. Only the correct pair may reach the memory port. The buffer is filled in descending slot order, so a design that ignores the address bits and fills slots in arrival order writes a reversed row. A foreign-row word written over slot 0 shows whether out-of-group data is really dropped. A page erase at an unaligned address, and a single-word write, each check the write stream word by word against a queue built from the requirements. The stream is also checked for words missing at the end.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  // Register select codes on the 3-bit bus address
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_KEY  = 3'd1;
  localparam logic [2:0] REG_ADDR = 3'd2;
  localparam logic [2:0] REG_DLO  = 3'd3;
  localparam logic [2:0] REG_DHI  = 3'd4;

  // Control register bit positions
  localparam int CTRL_START_BIT = 15;
  localparam int CTRL_ERR_BIT   = 14;

  // Unlock values, in order
  localparam logic [15:0] UNLOCK_A = 16'h0055;
  localparam logic [15:0] UNLOCK_B = 16'h00AA;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WORD = 2'd1,
    OP_ROW  = 2'd2,
    OP_PAGE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_e;

endpackage

// File: rtl/fp_keylock.sv
// Unlock tracker: two exact key writes on back-to-back accesses arm
// the block; the next access of any kind disarms it.
module fp_keylock
  import flashprog_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             key_wr,
  input  logic [BUS_W-1:0] key_val,
  output logic             armed
);

  key_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (acc) begin
      unique case (st_q)
        KS_IDLE: st_d = (key_wr && key_val == BUS_W'(UNLOCK_A)) ? KS_HALF : KS_IDLE;
        KS_HALF: st_d = (key_wr && key_val == BUS_W'(UNLOCK_B)) ? KS_ARMED : KS_IDLE;
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else        st_q <= st_d;
  end

  assign armed = (st_q == KS_ARMED);

endmodule

// File: rtl/fp_rowbuf.sv
// Holding buffer for one row: per-slot valid flags and a locked row group.
module fp_rowbuf #(
  parameter int WORD_W    = 24,
  parameter int ADDR_W    = 16,
  parameter int ROW_WORDS = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          clr,
  input  logic [$clog2(ROW_WORDS)-1:0]  rd_idx,
  output logic [WORD_W-1:0]             rd_data,
  output logic [ADDR_W-$clog2(ROW_WORDS)-1:0] grp_row,
  output logic                          full,
  output logic                          reject
);

  localparam int ROW_LOG = $clog2(ROW_WORDS);
  localparam int GRP_W   = ADDR_W - ROW_LOG;

  logic [ROW_WORDS-1:0] vld_q, vld_d;
  logic [GRP_W-1:0]     grp_q, grp_d;
  logic [WORD_W-1:0]    slot_q [ROW_WORDS];

  logic [GRP_W-1:0]   wr_row;
  logic [ROW_LOG-1:0] wr_idx;
  logic               empty;
  logic               accept;

  assign wr_row = wr_addr[ADDR_W-1:ROW_LOG];
  assign wr_idx = wr_addr[ROW_LOG-1:0];
  assign empty  = ~|vld_q;
  assign accept = wr_en && (empty || wr_row == grp_q);
  assign reject = wr_en && !accept;

  always_comb begin
    vld_d = vld_q;
    grp_d = grp_q;
    if (clr) begin
      vld_d = '0;
    end else if (accept) begin
      vld_d[wr_idx] = 1'b1;
      if (empty) grp_d = wr_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      grp_q <= '0;
    end else begin
      vld_q <= vld_d;
      grp_q <= grp_d;
    end
  end

  // Data slots carry no reset; the valid flags qualify them.
  always_ff @(posedge clk) begin
    if (accept) slot_q[wr_idx] <= wr_data;
  end

  assign rd_data = slot_q[rd_idx];
  assign grp_row = grp_q;
  assign full    = &vld_q;

endmodule

// File: rtl/fp_sequencer.sv
// Operation engine: streams words to the array port and times the stall.
module fp_sequencer
  import flashprog_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int ADDR_W    = 16,
  parameter int ROW_WORDS = 64,
  parameter int PAGE_ROWS = 8,
  parameter int OP_CYCLES = 600
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  input  op_e                          go_op,
  input  logic [ADDR_W-1:0]            go_base,
  input  logic [WORD_W-1:0]            word_data,
  input  logic [WORD_W-1:0]            row_data,
  output logic [$clog2(ROW_WORDS)-1:0] rd_idx,
  output logic                         busy,
  output logic                         done,
  output op_e                          done_op,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [WORD_W-1:0]            mem_wdata
);

  localparam int ROW_LOG    = $clog2(ROW_WORDS);
  localparam int PAGE_WORDS = ROW_WORDS * PAGE_ROWS;
  localparam int CNT_W      = $clog2(PAGE_WORDS + 1);
  localparam int TMR_W      = $clog2(OP_CYCLES + 1);

  logic              busy_q, busy_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [CNT_W-1:0]  n_words;

  always_comb begin
    unique case (op_q)
      OP_WORD: n_words = CNT_W'(1);
      OP_ROW:  n_words = CNT_W'(ROW_WORDS);
      OP_PAGE: n_words = CNT_W'(PAGE_WORDS);
      default: n_words = '0;
    endcase
  end

  assign mem_we   = busy_q && (idx_q < n_words);
  assign mem_addr = base_q + ADDR_W'(idx_q);
  assign rd_idx   = idx_q[ROW_LOG-1:0];
  assign done     = busy_q && (tmr_q == TMR_W'(OP_CYCLES - 1));
  assign done_op  = op_q;
  assign busy     = busy_q;

  always_comb begin
    unique case (op_q)
      OP_PAGE: mem_wdata = '1;
      OP_ROW:  mem_wdata = row_data;
      OP_WORD: mem_wdata = word_data;
      default: mem_wdata = '0;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    op_d   = op_q;
    base_d = base_q;
    idx_d  = idx_q;
    tmr_d  = tmr_q;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        op_d   = go_op;
        base_d = go_base;
        idx_d  = '0;
        tmr_d  = '0;
      end
    end else begin
      tmr_d = tmr_q + 1'b1;
      if (mem_we) idx_d = idx_q + 1'b1;
      if (done)   busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      base_q <= '0;
      idx_q  <= '0;
      tmr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      op_q   <= op_d;
      base_q <= base_d;
      idx_q  <= idx_d;
      tmr_q  <= tmr_d;
    end
  end

endmodule

// File: rtl/flashprog_ctl.sv
// Keyed self-programming controller: register bus front end, unlock
// gate, row holding buffer and operation sequencer.
module flashprog_ctl
  import flashprog_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int WORD_W    = 24,
  parameter int ADDR_W    = 16,
  parameter int ROW_WORDS = 64,
  parameter int PAGE_ROWS = 8,
  parameter int OP_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);

  localparam int HI_W     = WORD_W - BUS_W;
  localparam int ROW_LOG  = $clog2(ROW_WORDS);
  localparam int PAGE_LOG = $clog2(ROW_WORDS * PAGE_ROWS);
  localparam int GRP_W    = ADDR_W - ROW_LOG;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_in_n = rsync_q[1];

  // Bus decode; accesses during an operation are dropped
  logic acc, wr;
  logic wr_ctrl, wr_key, wr_addr, wr_lo, wr_hi;

  assign acc     = bus_valid && !busy;
  assign wr      = acc && bus_write;
  assign wr_ctrl = wr && (bus_addr == REG_CTRL);
  assign wr_key  = wr && (bus_addr == REG_KEY);
  assign wr_addr = wr && (bus_addr == REG_ADDR);
  assign wr_lo   = wr && (bus_addr == REG_DLO);
  assign wr_hi   = wr && (bus_addr == REG_DHI);

  // Registers
  op_e               op_q, op_d;
  logic              err_q, err_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_W-1:0]  lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;

  // Unit interconnect
  logic              armed;
  logic [WORD_W-1:0] row_data;
  logic [ROW_LOG-1:0] rd_idx;
  logic [GRP_W-1:0]  grp_row;
  logic              buf_full, buf_reject, buf_clr;
  logic              seq_done;
  op_e               seq_op;

  fp_keylock #(.BUS_W(BUS_W)) key_i (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .acc     (acc),
    .key_wr  (wr_key),
    .key_val (bus_wdata),
    .armed   (armed)
  );

  // Start qualification
  op_e               req_op;
  logic              start_try, op_ok, go;
  logic [ADDR_W-1:0] go_base;

  assign req_op    = op_e'(bus_wdata[1:0]);
  assign start_try = wr_ctrl && bus_wdata[CTRL_START_BIT];
  assign op_ok     = (req_op != OP_NONE) && ((req_op != OP_ROW) || buf_full);
  assign go        = start_try && armed && op_ok;

  always_comb begin
    unique case (req_op)
      OP_PAGE: go_base = {addr_q[ADDR_W-1:PAGE_LOG], {PAGE_LOG{1'b0}}};
      OP_ROW:  go_base = {grp_row, {ROW_LOG{1'b0}}};
      default: go_base = addr_q;
    endcase
  end

  fp_rowbuf #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .ROW_WORDS (ROW_WORDS)
  ) buf_i (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .wr_en   (wr_hi),
    .wr_addr (addr_q),
    .wr_data ({bus_wdata[HI_W-1:0], lo_q}),
    .clr     (buf_clr),
    .rd_idx  (rd_idx),
    .rd_data (row_data),
    .grp_row (grp_row),
    .full    (buf_full),
    .reject  (buf_reject)
  );

  fp_sequencer #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .ROW_WORDS (ROW_WORDS),
    .PAGE_ROWS (PAGE_ROWS),
    .OP_CYCLES (OP_CYCLES)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_in_n),
    .go        (go),
    .go_op     (req_op),
    .go_base   (go_base),
    .word_data ({hi_q, lo_q}),
    .row_data  (row_data),
    .rd_idx    (rd_idx),
    .busy      (busy),
    .done      (seq_done),
    .done_op   (seq_op),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  // Any program operation empties the holding buffer when it ends
  assign buf_clr = seq_done && ((seq_op == OP_WORD) || (seq_op == OP_ROW));

  // Register next state
  always_comb begin
    op_d   = op_q;
    err_d  = err_q;
    addr_d = addr_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (wr_ctrl) begin
      op_d = req_op;
      if (bus_wdata[CTRL_ERR_BIT]) err_d = 1'b0;
    end
    if ((start_try && !go) || buf_reject) err_d = 1'b1;
    if (wr_addr) addr_d = bus_wdata[ADDR_W-1:0];
    if (wr_lo)   lo_d   = bus_wdata;
    if (wr_hi)   hi_d   = bus_wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      op_q   <= OP_NONE;
      err_q  <= 1'b0;
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      op_q   <= op_d;
      err_q  <= err_d;
      addr_q <= addr_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CTRL_START_BIT] = busy;
        bus_rdata[CTRL_ERR_BIT]   = err_q;
        bus_rdata[1:0]            = op_q;
      end
      REG_ADDR: bus_rdata = BUS_W'(addr_q);
      REG_DLO:  bus_rdata = lo_q;
      REG_DHI:  bus_rdata = BUS_W'(hi_q);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fp_checker.sv
// Protocol checker attached to every flashprog_ctl instance.
module fp_checker #(
  parameter int BUS_W     = 16,
  parameter int ADDR_W    = 16,
  parameter int OP_CYCLES = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              key_read,
  input logic              start_wr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  // R5: the array strobe only fires inside the stall window
  a_r5_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R5: the stall lasts exactly the configured count
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == OP_CYCLES);

  // R3: busy only rises right after a start write on the bus
  a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr));

  // R2: the key register never reads back anything
  a_r2_key_zero: assert property (@(posedge clk) disable iff (!rst_n)
    key_read |-> bus_rdata == '0);

  // R6 / R7: streamed words go to consecutive ascending addresses
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1);

endmodule

bind flashprog_ctl fp_checker #(
  .BUS_W     (BUS_W),
  .ADDR_W    (ADDR_W),
  .OP_CYCLES (OP_CYCLES)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .key_read  (bus_valid && !bus_write && bus_addr == 3'd1),
  .start_wr  (bus_valid && bus_write && bus_addr == 3'd0 && bus_wdata[15]),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/flashprog_ctl_tb_top.sv
module flashprog_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OPC        = 600;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        busy;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [23:0] mem_wdata;

  flashprog_ctl #(.OP_CYCLES(OPC)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  int checks = 0;
  int errors = 0;
  int busy_cnt = 0;
  bit done_flag = 0;

  logic [39:0] exp_q[$];   // {addr, data}
  string       tag_q[$];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string req, input string what,
                          input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares every array write against the expected queue
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3 unexpected array write: actual %0h expected none",
                 {mem_addr, mem_wdata});
      end else begin
        logic [39:0] it;
        string       tg;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        check_eq(tg, "array write", {mem_addr, mem_wdata}, it);
      end
    end
  end

  // Driver tasks (called on a falling edge)
  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(3'd1, 16'h0055);
    bus_wr(3'd1, 16'h00AA);
  endtask

  task automatic push(input string tg, input logic [15:0] a, input logic [23:0] d);
    exp_q.push_back({a, d});
    tag_q.push_back(tg);
  endtask

  task automatic expect_err(input string req, input bit e);
    logic [15:0] v;
    bus_rd(3'd0, v);
    check_eq(req, "error flag", 40'(v[14]), 40'(e));
    check_eq(req, "busy idle", 40'(busy), 40'd0);
  endtask

  task automatic clear_err();
    bus_wr(3'd0, 16'h4000);
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input bit poke);
    logic [15:0] v;
    busy_cnt = 0;
    unlock();
    bus_wr(3'd0, 16'h8000 | 16'(op));
    check_eq("R5", "busy after start", 40'(busy), 40'd1);
    bus_rd(3'd0, v);
    check_eq("R5", "start bit while running", 40'(v[15]), 40'd1);
    if (poke) begin
      bus_wr(3'd2, 16'h7777);
      bus_wr(3'd3, 16'h1111);
    end
    while (busy) @(negedge clk);
    check_eq("R5", "stall length", 40'(busy_cnt), 40'(OPC));
    bus_rd(3'd0, v);
    check_eq("R5", "start bit cleared", 40'(v[15]), 40'd0);
    check_eq(req, "words left unwritten", 40'(exp_q.size()), 40'd0);
    check_eq(req, "error flag after op", 40'(v[14]), 40'd0);
  endtask

  function automatic logic [23:0] rowval(input int i);
    return {8'(i * 3 + 1), 16'(16'hA500 + i * 16'h0107)};
  endfunction

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    bus_rd(3'd0, v);
    check_eq("R1", "control after reset", 40'(v), 40'd0);
    check_eq("R1", "busy after reset", 40'(busy), 40'd0);
    check_eq("R1", "strobe after reset", 40'(mem_we), 40'd0);

    // R2: key reads zero even after a key write
    bus_wr(3'd1, 16'h0055);
    bus_rd(3'd1, v);
    check_eq("R2", "key readback", 40'(v), 40'd0);

    // R3: start with no unlock
    bus_wr(3'd0, 16'h8001);
    expect_err("R3", 1'b1);
    // R13: write-one clears the flag
    clear_err();
    expect_err("R13", 1'b0);

    // R3: a read between the key writes breaks the unlock
    bus_wr(3'd1, 16'h0055);
    bus_rd(3'd2, v);
    bus_wr(3'd1, 16'h00AA);
    bus_wr(3'd0, 16'h8001);
    expect_err("R3", 1'b1);
    clear_err();

    // R3: reversed key values
    bus_wr(3'd1, 16'h00AA);
    bus_wr(3'd1, 16'h0055);
    bus_wr(3'd0, 16'h8001);
    expect_err("R3", 1'b1);
    clear_err();

    // R8: single-word program; R12: writes during busy dropped
    bus_wr(3'd2, 16'h1234);
    bus_wr(3'd3, 16'hBEEF);
    bus_wr(3'd4, 16'h005A);
    push("R8", 16'h1234, 24'h5ABEEF);
    run_op("R8", 2'd1, 1'b1);
    bus_rd(3'd2, v);
    check_eq("R12", "address kept during busy", 40'(v), 40'h1234);
    bus_rd(3'd3, v);
    check_eq("R12", "low half kept during busy", 40'(v), 40'hBEEF);

    // R4: the unlock was used up
    bus_wr(3'd0, 16'h8001);
    expect_err("R4", 1'b1);
    clear_err();

    // R9: fill row 5 in descending slot order, leaving slot 0 empty
    for (int i = 63; i >= 1; i--) begin
      bus_wr(3'd2, 16'h0140 + 16'(i));
      bus_wr(3'd3, rowval(i)[15:0]);
      bus_wr(3'd4, 16'(rowval(i)[23:16]));
    end
    // R11: incomplete buffer
    unlock();
    bus_wr(3'd0, 16'h8002);
    expect_err("R11", 1'b1);
    clear_err();
    bus_wr(3'd2, 16'h0140);
    bus_wr(3'd3, rowval(0)[15:0]);
    bus_wr(3'd4, 16'(rowval(0)[23:16]));
    expect_err("R9", 1'b0);
    // R10: foreign-row word aimed at slot 0
    bus_wr(3'd2, 16'h0200);
    bus_wr(3'd3, 16'hDEAD);
    bus_wr(3'd4, 16'h00EE);
    expect_err("R10", 1'b1);
    clear_err();

    // R7: row program, then R10 data must not have landed
    for (int i = 0; i < 64; i++) push("R7", 16'h0140 + 16'(i), rowval(i));
    run_op("R7", 2'd2, 1'b0);
    // R7: buffer is empty afterwards
    unlock();
    bus_wr(3'd0, 16'h8002);
    expect_err("R7", 1'b1);
    clear_err();

    // R6: page erase at an unaligned address
    bus_wr(3'd2, 16'h0A37);
    for (int i = 0; i < 512; i++) push("R6", 16'h0A00 + 16'(i), 24'hFFFFFF);
    run_op("R6", 2'd3, 1'b0);

    // R14: operation code 0
    unlock();
    bus_wr(3'd0, 16'h8000);
    expect_err("R14", 1'b1);
    clear_err();

    repeat (5) @(negedge clk);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule